// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block monitors a bank of general-purpose input lines and records edge events on them in a sticky pending register. Each line has two enable bits: one arms rising-edge detection and the other arms falling-edge detection. Setting both arms detection of either edge. Clearing both masks the line completely. Software clears pending bits by writing ones to them. Writing zero to a pending bit has no effect.

The first eight pending bits each drive a dedicated interrupt output toward the system interrupt controller. All higher pending bits are merged into one shared summary interrupt. A handler for the shared line reads the pending register, writes the same value back, and repeats until the register reads zero. An edge that arrives between the read and the write-back stays pending, because only the bits written as one are cleared.

Each input passes through a two-flop synchroniser before edge detection. A small word-addressed register bus gives access to the two enable registers and the pending register.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: After reset the rising-enable register, the falling-enable register and the pending register read zero, and all interrupt outputs are low.
- R2: With its rising enable set, a 0-to-1 change on a line sets that line's pending bit. The bit is visible after the third rising clock edge following the input change, and is not yet set after the second.
- R3: With its falling enable set, a 1-to-0 change on a line sets that line's pending bit.
- R4: With both enables of a line set, either direction of change sets its pending bit.
- R5: A pending bit is never set by an edge whose direction is not enabled. A line with both enables clear never sets its pending bit.
- R6: A pending bit stays set after the input returns to its former level, until it is cleared by software.
- R7: A write to the pending register (offset 0x8) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R8: Writing 0xFFFFFFF to the pending register clears all 28 pending bits.
- R9: When a new edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R10: Interrupt output irq_line[i] is high exactly while pending bit i is set, for i from 0 to 7.
- R11: irq_summary is high exactly while any of pending bits 8 to 27 is set.
- R12: The rising-enable register is at offset 0x0, the falling-enable register at 0x4 and the pending register at 0x8. Each reads back its own value, a pending-register write leaves both enable registers unchanged, and reads of any other offset return zero.
- R13: Reading the pending register and writing the read value back keeps pending any edge that arrived after the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | 28 | Asynchronous general-purpose input lines |
| bus_en | input | 1 | Register access strobe; a write takes effect only when this is high |
| bus_wr | input | 1 | Write enable for the current access |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 28 | Write data |
| bus_rdata | output | 28 | Read data for bus_addr, combinational |
| irq_line | output | 8 | Dedicated interrupts, one per pending bit 0 to 7 |
| irq_summary | output | 1 | OR of pending bits 8 to 27 |

## Verification
An input change at a falling clock edge becomes a pending bit after three rising edges: two in the synchroniser and one in the pending register. The bench therefore waits at least four cycles before reading a result. The R2 timing check samples just after the second and just after the third rising edge. A register write counts from the rising edge that samples it, and read data and interrupt outputs are combinational from the registers. All outputs are sampled at falling edges or shortly after. For R9 the clearing write is placed so that the same rising edge that latches the new edge also samples the write.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int unsigned REG_ADDR_W = 4;

    localparam logic [REG_ADDR_W-1:0] OFFS_RISE_EN = 4'h0;
    localparam logic [REG_ADDR_W-1:0] OFFS_FALL_EN = 4'h4;
    localparam logic [REG_ADDR_W-1:0] OFFS_PEND    = 4'h8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RISE,
        SEL_FALL,
        SEL_PEND
    } reg_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic pend;
    } wr_strobe_t;

    function automatic reg_sel_e reg_decode(input logic [REG_ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFFS_RISE_EN: s = SEL_RISE;
            OFFS_FALL_EN: s = SEL_FALL;
            OFFS_PEND:    s = SEL_PEND;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int unsigned W = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = prev_q;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int unsigned W = 28
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic went_up;
        logic went_down;
        assign went_up   = cur[i] & ~prev[i];
        assign went_down = ~cur[i] & prev[i];
        assign evt[i]    = (went_up & rise_en[i]) | (went_down & fall_en[i]);
    end
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W = 28
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_en,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]          bus_wdata,
    input  logic [W-1:0]          pend,
    output logic [W-1:0]          rise_en,
    output logic [W-1:0]          fall_en,
    output logic [W-1:0]          pend_clr,
    output logic [W-1:0]          bus_rdata
);
    reg_sel_e   sel;
    wr_strobe_t wstb;
    logic       wr_go;
    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;

    assign sel   = reg_decode(bus_addr);
    assign wr_go = bus_en & bus_wr;

    always_comb begin
        wstb.rise = wr_go && (sel == SEL_RISE);
        wstb.fall = wr_go && (sel == SEL_FALL);
        wstb.pend = wr_go && (sel == SEL_PEND);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            if (wstb.rise) rise_q <= bus_wdata;
            if (wstb.fall) fall_q <= bus_wdata;
        end
    end

    assign pend_clr = wstb.pend ? bus_wdata : '0;
    assign rise_en  = rise_q;
    assign fall_en  = fall_q;

    always_comb begin
        case (sel)
            SEL_RISE: bus_rdata = rise_q;
            SEL_FALL: bus_rdata = fall_q;
            SEL_PEND: bus_rdata = pend;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int unsigned W = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);
    logic [W-1:0] pend_q;

    // A fresh event outranks a clear aimed at the same bit.
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr) | evt;
    end

    assign pend = pend_q;
endmodule

// File: rtl/gpio_edge_irq_unit.sv
module gpio_edge_irq_unit
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 28,
    parameter int unsigned NUM_DIRECT = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LINES-1:0]  gpio_in,
    input  logic                  bus_en,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [NUM_LINES-1:0]  bus_wdata,
    output logic [NUM_LINES-1:0]  bus_rdata,
    output logic [NUM_DIRECT-1:0] irq_line,
    output logic                  irq_summary
);
    localparam int unsigned NUM_SHARED = NUM_LINES - NUM_DIRECT;

    logic [NUM_LINES-1:0] cur_lvl;
    logic [NUM_LINES-1:0] prev_lvl;
    logic [NUM_LINES-1:0] rise_en_q;
    logic [NUM_LINES-1:0] fall_en_q;
    logic [NUM_LINES-1:0] edge_evt;
    logic [NUM_LINES-1:0] pend_clr;
    logic [NUM_LINES-1:0] pend_q;

    gpio_edge_sync #(.W(NUM_LINES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (gpio_in),
        .cur  (cur_lvl),
        .prev (prev_lvl)
    );

    gpio_edge_detect #(.W(NUM_LINES)) u_detect (
        .cur     (cur_lvl),
        .prev    (prev_lvl),
        .rise_en (rise_en_q),
        .fall_en (fall_en_q),
        .evt     (edge_evt)
    );

    gpio_edge_regs #(.W(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend      (pend_q),
        .rise_en   (rise_en_q),
        .fall_en   (fall_en_q),
        .pend_clr  (pend_clr),
        .bus_rdata (bus_rdata)
    );

    gpio_edge_status #(.W(NUM_LINES)) u_status (
        .clk  (clk),
        .rst  (rst),
        .evt  (edge_evt),
        .clr  (pend_clr),
        .pend (pend_q)
    );

    assign irq_line = pend_q[NUM_DIRECT-1:0];

    if (NUM_SHARED > 0) begin : g_shared
        assign irq_summary = |pend_q[NUM_LINES-1:NUM_DIRECT];
    end else begin : g_no_shared
        assign irq_summary = 1'b0;
    end
endmodule

// File: rtl/gpio_edge_irq_unit_chk.sv
module gpio_edge_irq_unit_chk
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W = 28
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_en,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [W-1:0]          bus_wdata,
    input logic [W-1:0]          pend,
    input logic [W-1:0]          evt,
    input logic [W-1:0]          rise_en,
    input logic [W-1:0]          fall_en
);
    logic         pend_write;
    logic [W-1:0] clr_vec;

    always_comb begin
        pend_write = bus_en && bus_wr && (bus_addr == OFFS_PEND);
        clr_vec    = pend_write ? bus_wdata : '0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pend == '0 && rise_en == '0 && fall_en == '0));

    // R5
    masked_line_chk: assert property (@(posedge clk) disable iff (rst)
        (evt & ~(rise_en | fall_en)) == '0);

    // R5
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(evt)) == '0));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend) & ~$past(clr_vec) & ~pend) == '0));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pend_write |=> ((pend & $past(clr_vec) & ~$past(evt)) == '0));

    // R9
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(evt) & ~pend) == '0));
endmodule

bind gpio_edge_irq_unit gpio_edge_irq_unit_chk #(.W(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend      (pend_q),
    .evt       (edge_evt),
    .rise_en   (rise_en_q),
    .fall_en   (fall_en_q)
);

// File: tb/gpio_edge_irq_unit_tb.sv
module gpio_edge_irq_unit_tb;
    localparam int N = 28;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] gpio_in = '0;
    logic         bus_en = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = 4'h0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [7:0]   irq_line;
    logic         irq_summary;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    gpio_edge_irq_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .gpio_in     (gpio_in),
        .bus_en      (bus_en),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_line    (irq_line),
        .irq_summary (irq_summary)
    );

    typedef struct packed {
        logic [4:0] line;
        logic       rise;
        logic       fall;
        logic       from_lvl;
        logic       to_lvl;
        logic       hit;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{5'd2,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1},   // R2 rising armed
        '{5'd2,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},   // R5 falling not armed
        '{5'd12, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},   // R3 falling armed
        '{5'd12, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},   // R5 rising not armed
        '{5'd20, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},   // R4 both, up
        '{5'd20, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},   // R4 both, down
        '{5'd27, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},   // R5 masked line
        '{5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},   // R5 masked line
        '{5'd7,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1},   // R10 top direct line
        '{5'd8,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1}    // R11 first shared line
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] r;
        logic [N-1:0] snap;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(4'h0, r); chk("R1 rise_en", r, 0);
        rd(4'h4, r); chk("R1 fall_en", r, 0);
        rd(4'h8, r); chk("R1 pending", r, 0);
        chk("R1 irqs", {irq_summary, irq_line}, 0);

        // R12 register map and readback
        wr(4'h0, 28'hA5A5A5A);
        wr(4'h4, 28'h5A5A5A5);
        wr(4'h8, 28'hFFFFFFF);
        rd(4'h0, r); chk("R12 rise readback", r, 28'hA5A5A5A);
        rd(4'h4, r); chk("R12 fall readback", r, 28'h5A5A5A5);
        rd(4'hC, r); chk("R12 unmapped", r, 0);
        rd(4'h2, r); chk("R12 unaligned", r, 0);

        // Table walk: R2 R3 R4 R5 R10 R11
        foreach (VECS[k]) begin
            vec_t v = VECS[k];
            wr(4'h0, v.rise ? (28'd1 << v.line) : 28'd0);
            wr(4'h4, v.fall ? (28'd1 << v.line) : 28'd0);
            @(negedge clk) gpio_in = v.from_lvl ? (28'd1 << v.line) : 28'd0;
            idle(5);
            wr(4'h8, 28'hFFFFFFF);
            @(negedge clk) gpio_in = v.to_lvl ? (28'd1 << v.line) : 28'd0;
            idle(5);
            rd(4'h8, r);
            chk($sformatf("R2-5 vec%0d pending", k), r, v.hit ? (28'd1 << v.line) : 28'd0);
            if (v.line < 8)
                chk($sformatf("R10 vec%0d irq_line", k), irq_line,
                    v.hit ? (8'd1 << v.line) : 8'd0);
            chk($sformatf("R11 vec%0d irq_summary", k), irq_summary, v.hit && v.line >= 8);
            wr(4'h8, 28'hFFFFFFF);
        end
        @(negedge clk) gpio_in = '0;
        idle(5);

        // R2 latency: set after the third rising edge, not after the second
        wr(4'h0, 28'h0000010);
        wr(4'h4, 28'h0000000);
        wr(4'h8, 28'hFFFFFFF);
        @(negedge clk) gpio_in[4] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); chk("R2 not yet after 2 edges", irq_line[4], 0);
        @(posedge clk);
        @(negedge clk); chk("R2 set after 3 edges", irq_line[4], 1);

        // R6 sticky after input returns
        gpio_in[4] = 1'b0;
        idle(5);
        rd(4'h8, r); chk("R6 sticky", r, 28'h0000010);

        // R7 partial clear and zero write
        wr(4'h0, 28'h0008018);
        @(negedge clk) gpio_in[3] = 1'b1; gpio_in[15] = 1'b1;
        idle(5);
        rd(4'h8, r); chk("R7 setup", r, 28'h0008018);
        wr(4'h8, 28'h0000000);
        rd(4'h8, r); chk("R7 zero write keeps", r, 28'h0008018);
        wr(4'h8, 28'h0000008);
        rd(4'h8, r); chk("R7 clear one bit", r, 28'h0008010);
        rd(4'h0, r); chk("R12 enables untouched", r, 28'h0008018);

        // R8 full clear
        wr(4'h8, 28'hFFFFFFF);
        rd(4'h8, r); chk("R8 all cleared", r, 0);
        chk("R8 irqs low", {irq_summary, irq_line}, 0);
        @(negedge clk) gpio_in = '0;
        idle(5);

        // R9 edge and clear in the same cycle
        wr(4'h0, 28'h0000020);
        wr(4'h8, 28'hFFFFFFF);
        @(negedge clk) gpio_in[5] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 28'h0000020;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
        rd(4'h8, r); chk("R9 edge wins", r, 28'h0000020);
        wr(4'h8, 28'h0000020);
        rd(4'h8, r); chk("R9 later clear", r, 0);

        // R13 read, new edge, write back
        wr(4'h0, 28'h0000600);
        @(negedge clk) gpio_in[9] = 1'b1;
        idle(5);
        rd(4'h8, snap);
        chk("R13 snapshot", snap, 28'h0000200);
        @(negedge clk) gpio_in[10] = 1'b1;
        idle(5);
        wr(4'h8, snap);
        rd(4'h8, r); chk("R13 late edge pending", r, 28'h0000400);
        chk("R11 summary still high", irq_summary, 1);
        wr(4'h8, r);
        rd(4'h8, r); chk("R13 drained", r, 0);
        chk("R11 summary low", irq_summary, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule